// File: doc/BRIEF.md
# Table-Driven Converter Scan Sequencer

This block drives a successive-approximation converter through a list of scan steps kept in a small on-chip table. Each table entry names the channels to convert: up to eight direct inputs and two multiplexed inputs. It also chooses whether sampling waits on one of four shared delay timers, sets whether each channel's conversions are averaged, and says what the sequencer does once the entry is finished. A host loads the table and the timer presets through two simple write ports. Scans are then started with a trigger that carries the first entry index.

The converter itself sits behind an abstract request/done handshake. The sequencer raises a one-cycle convert request with a channel tag and waits for the done pulse and its sample. It then emits one tagged result per channel, averaged when the entry asks for it. The enable, trigger and entry-index controls act only while the unlock input is high, so a host can hold them at any value while locked.

Top module: `adc_scan_seq`

## Requirements
- R1: A table word written at an index sets that entry's fields at these bit positions: [7:0] direct-channel mask, [8] mux-0 enable, [12:9] mux-0 select, [13] mux-1 enable, [17:14] mux-1 select, [18] delay enable, [20:19] timer select, [21] averaging enable, [23:22] averaging code, [25:24] next action. With unlock and enable high, a trigger from idle starts a scan at `ctl_entry`, and `busy` is high from the next cycle until the scan ends.
- R2: Within an entry, the enabled direct channels (tags 0 to 7) are converted in ascending order, then mux 0 (tag 16 + select), then mux 1 (tag 16 + select). Only one convert request is outstanding at a time, and the next request waits for the converter's done.
- R3: A timer programmed with value N, selected by an entry with delay enabled, makes that entry's first convert request come exactly N+1 cycles later than it would with the delay disabled (N from 0 to 1023).
- R4: With averaging enabled and code c, each channel is converted 2^c times and one result equal to floor(sum / 2^c) is emitted. With averaging disabled, each channel gets exactly one conversion, whatever the code.
- R5: Next action 0 ends the scan and returns to idle. Next action 1 proceeds to the following entry, and the last entry (31) wraps to entry 0.
- R6: Next action 2 ends the scan with `busy` low. The next accepted trigger restarts at the stored start entry and disregards `ctl_entry`.
- R7: Next action 3 restarts at the stored start entry at once, without a trigger.
- R8: While `ctl_unlock` is low, `ctl_trigger`, `ctl_enable` and `ctl_entry` have no effect: idle stays idle, and a running scan completes unchanged.
- R9: A trigger that arrives while `busy` is high is ignored, and the running scan's results are unchanged.
- R10: Unlock high with enable low aborts any scan or pause at once. `busy` is low from the next cycle and no further requests are issued.
- R11: After reset, `busy`, `cnv_req` and `res_valid` are low.
- R12: An entry with no channel enabled issues no request and goes straight to its next action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 5 | Table write index |
| tbl_wdata | input | 26 | Table entry word (layout in R1) |
| tmr_we | input | 1 | Timer preset write strobe |
| tmr_sel | input | 2 | Timer to write |
| tmr_wdata | input | 10 | Timer preset N (delay N+1) |
| ctl_unlock | input | 1 | Lets the other control inputs act |
| ctl_enable | input | 1 | Enable; low while unlocked aborts |
| ctl_trigger | input | 1 | Start request |
| ctl_entry | input | 5 | Start entry index |
| busy | output | 1 | Scan in progress |
| cnv_req | output | 1 | One-cycle convert request |
| cnv_chan | output | 5 | Channel tag of the request |
| cnv_done | input | 1 | Converter finished, sample valid |
| cnv_data | input | 12 | Converter sample |
| res_valid | output | 1 | Result strobe |
| res_tag | output | 5 | Channel tag of the result |
| res_data | output | 12 | Result (averaged when enabled) |

## Verification
The bench builds the block with its default sizes: a 32-entry table, 10-bit timers and 12-bit samples. This makes the wrap from entry 31 to entry 0 and the longest 1024-cycle delay directly reachable. At these sizes it sweeps all 256 direct masks, all sixteen mux selects on both multiplexers, and every averaging code with averaging on and off. It then checks each result against sums of the samples its own converter model returned.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DIR_N  = 8;
    localparam int MSEL_W = 4;
    localparam int TSEL_W = 2;
    localparam int AVG_W  = 2;

    localparam int SLOT_N = DIR_N + 2;
    localparam int SLOT_W = $clog2(SLOT_N);
    localparam int TAG_W  = MSEL_W + 1;
    localparam int REP_W  = (1 << AVG_W) - 1;

    typedef enum logic [1:0] {
        NX_STOP  = 2'd0,
        NX_STEP  = 2'd1,
        NX_PAUSE = 2'd2,
        NX_LOOP  = 2'd3
    } next_act_e;

    typedef struct packed {
        next_act_e          nxt;
        logic [AVG_W-1:0]   avg_log;
        logic               avg_on;
        logic [TSEL_W-1:0]  tsel;
        logic               ts_on;
        logic [MSEL_W-1:0]  m1_sel;
        logic               m1_on;
        logic [MSEL_W-1:0]  m0_sel;
        logic               m0_on;
        logic [DIR_N-1:0]   dir_mask;
    } scan_ent_t;

    localparam int ENT_W = $bits(scan_ent_t);

    typedef enum logic [2:0] {
        S_IDLE,
        S_PAUSE,
        S_LOAD,
        S_ARM,
        S_DELAY,
        S_PICK,
        S_REQ,
        S_WAIT
    } seq_state_e;

    // Lowest set position of the pending-slot vector.
    function automatic logic [SLOT_W-1:0] lowest_slot(input logic [SLOT_N-1:0] v);
        logic [SLOT_W-1:0] r;
        r = '0;
        for (int i = SLOT_N - 1; i >= 0; i--) begin
            if (v[i]) r = SLOT_W'(i);
        end
        return r;
    endfunction

    // Direct slots map to their own number, mux slots to 16 + select.
    function automatic logic [TAG_W-1:0] slot_tag(input scan_ent_t e,
                                                  input logic [SLOT_W-1:0] s);
        if (s < SLOT_W'(DIR_N))       return TAG_W'(s);
        else if (s == SLOT_W'(DIR_N)) return {1'b1, e.m0_sel};
        else                          return {1'b1, e.m1_sel};
    endfunction

endpackage

// File: rtl/adc_seq_table.sv
module adc_seq_table
    import adc_seq_pkg::*;
#(
    parameter int N_ENT = 32,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  scan_ent_t        wdata,
    input  logic [IDX_W-1:0] raddr,
    output scan_ent_t        rdata
);

    scan_ent_t mem [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)                            mem[g] <= '0;
            else if (we && waddr == IDX_W'(g))  mem[g] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/adc_seq_timers.sv
module adc_seq_timers
    import adc_seq_pkg::*;
#(
    parameter int TMR_W = 10,
    localparam int N_TMR = 1 << TSEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [TSEL_W-1:0] wsel,
    input  logic [TMR_W-1:0]  wdata,
    input  logic              load,
    input  logic [TSEL_W-1:0] lsel,
    input  logic              run,
    output logic              zero
);

    logic [TMR_W-1:0] preset [N_TMR];
    logic [TMR_W-1:0] cnt;

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        always_ff @(posedge clk) begin
            if (rst)                             preset[g] <= '0;
            else if (we && wsel == TSEL_W'(g))   preset[g] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    cnt <= '0;
        else if (load)              cnt <= preset[lsel];
        else if (run && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/adc_seq_avg.sv
module adc_seq_avg
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 12,
    localparam int ACC_W = RES_W + REP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             add,
    input  logic [RES_W-1:0] din,
    input  logic [AVG_W-1:0] shift,
    output logic [RES_W-1:0] avg_out
);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum_nxt;

    assign sum_nxt = acc + ACC_W'(din);
    assign avg_out = RES_W'(sum_nxt >> shift);

    always_ff @(posedge clk) begin
        if (rst || clr) acc <= '0;
        else if (add)   acc <= sum_nxt;
    end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int N_ENT = 32,
    parameter int TMR_W = 10,
    parameter int RES_W = 12,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_addr,
    input  logic [ENT_W-1:0]  tbl_wdata,
    input  logic              tmr_we,
    input  logic [TSEL_W-1:0] tmr_sel,
    input  logic [TMR_W-1:0]  tmr_wdata,
    input  logic              ctl_unlock,
    input  logic              ctl_enable,
    input  logic              ctl_trigger,
    input  logic [IDX_W-1:0]  ctl_entry,
    output logic              busy,
    output logic              cnv_req,
    output logic [TAG_W-1:0]  cnv_chan,
    input  logic              cnv_done,
    input  logic [RES_W-1:0]  cnv_data,
    output logic              res_valid,
    output logic [TAG_W-1:0]  res_tag,
    output logic [RES_W-1:0]  res_data
);

    seq_state_e        state;
    logic [IDX_W-1:0]  cur_idx;
    logic [IDX_W-1:0]  start_idx;
    scan_ent_t         ent_q;
    scan_ent_t         tbl_rd;
    logic [SLOT_N-1:0] remain;
    logic [SLOT_W-1:0] slot_q;
    logic [REP_W-1:0]  rep_q;
    logic [REP_W-1:0]  rep_goal;
    logic              rep_last;
    logic              tmr_zero;
    logic              tmr_load;
    logic [RES_W-1:0]  avg_val;
    logic              go;
    logic              abort;
    logic [IDX_W-1:0]  step_idx;

    adc_seq_table #(.N_ENT(N_ENT)) u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (scan_ent_t'(tbl_wdata)),
        .raddr (cur_idx),
        .rdata (tbl_rd)
    );

    assign tmr_load = (state == S_ARM) && ent_q.ts_on;

    adc_seq_timers #(.TMR_W(TMR_W)) u_timers (
        .clk   (clk),
        .rst   (rst),
        .we    (tmr_we),
        .wsel  (tmr_sel),
        .wdata (tmr_wdata),
        .load  (tmr_load),
        .lsel  (ent_q.tsel),
        .run   (state == S_DELAY),
        .zero  (tmr_zero)
    );

    adc_seq_avg #(.RES_W(RES_W)) u_avg (
        .clk     (clk),
        .rst     (rst),
        .clr     (state == S_PICK),
        .add     ((state == S_WAIT) && cnv_done),
        .din     (cnv_data),
        .shift   (ent_q.avg_on ? ent_q.avg_log : '0),
        .avg_out (avg_val)
    );

    assign go       = ctl_unlock && ctl_enable && ctl_trigger;
    assign abort    = ctl_unlock && !ctl_enable;
    assign rep_goal = ~({REP_W{1'b1}} << ent_q.avg_log);
    assign rep_last = !ent_q.avg_on || (rep_q == rep_goal);
    assign step_idx = (cur_idx == IDX_W'(N_ENT - 1)) ? '0 : cur_idx + 1'b1;

    assign busy     = (state != S_IDLE) && (state != S_PAUSE);
    assign cnv_req  = (state == S_REQ);
    assign cnv_chan = slot_tag(ent_q, slot_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cur_idx   <= '0;
            start_idx <= '0;
            ent_q     <= '0;
            remain    <= '0;
            slot_q    <= '0;
            rep_q     <= '0;
            res_valid <= 1'b0;
            res_tag   <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b0;
            if (abort) begin
                state <= S_IDLE;
            end else begin
                unique case (state)
                    S_IDLE: begin
                        if (go) begin
                            cur_idx   <= ctl_entry;
                            start_idx <= ctl_entry;
                            state     <= S_LOAD;
                        end
                    end
                    S_PAUSE: begin
                        if (go) begin
                            cur_idx <= start_idx;
                            state   <= S_LOAD;
                        end
                    end
                    S_LOAD: begin
                        ent_q  <= tbl_rd;
                        remain <= {tbl_rd.m1_on, tbl_rd.m0_on, tbl_rd.dir_mask};
                        state  <= S_ARM;
                    end
                    S_ARM: begin
                        state <= ent_q.ts_on ? S_DELAY : S_PICK;
                    end
                    S_DELAY: begin
                        if (tmr_zero) state <= S_PICK;
                    end
                    S_PICK: begin
                        if (remain != '0) begin
                            slot_q <= lowest_slot(remain);
                            rep_q  <= '0;
                            state  <= S_REQ;
                        end else begin
                            unique case (ent_q.nxt)
                                NX_STOP:  state <= S_IDLE;
                                NX_STEP: begin
                                    cur_idx <= step_idx;
                                    state   <= S_LOAD;
                                end
                                NX_PAUSE: state <= S_PAUSE;
                                NX_LOOP: begin
                                    cur_idx <= start_idx;
                                    state   <= S_LOAD;
                                end
                            endcase
                        end
                    end
                    S_REQ: begin
                        state <= S_WAIT;
                    end
                    S_WAIT: begin
                        if (cnv_done) begin
                            if (rep_last) begin
                                res_valid      <= 1'b1;
                                res_tag        <= cnv_chan;
                                res_data       <= avg_val;
                                remain[slot_q] <= 1'b0;
                                state          <= S_PICK;
                            end else begin
                                rep_q <= rep_q + 1'b1;
                                state <= S_REQ;
                            end
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
    import adc_seq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ctl_unlock,
    input logic             ctl_enable,
    input logic             busy,
    input logic             cnv_req,
    input logic             cnv_done,
    input logic             res_valid,
    input logic [TAG_W-1:0] res_tag
);

    // R2: a request is a single-cycle pulse; the next one needs a done first
    a_r2_single_req: assert property (@(posedge clk) disable iff (rst)
        cnv_req |=> !cnv_req);

    // R2: result tags are either direct (0..7) or mux (16 and up)
    a_r2_tag_legal: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_tag < TAG_W'(DIR_N) || res_tag[TAG_W-1]));

    // R1: requests only occur inside a scan
    a_r1_req_in_scan: assert property (@(posedge clk) disable iff (rst)
        cnv_req |-> busy);

    // R4: every result follows a converter done
    a_r4_res_after_done: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(cnv_done));

    // R8: locked and not scanning stays not scanning
    a_r8_locked_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ctl_unlock) |=> !busy);

    // R10: unlocked disable ends any scan next cycle
    a_r10_abort: assert property (@(posedge clk) disable iff (rst)
        (ctl_unlock && !ctl_enable) |=> (!busy && !cnv_req));

endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl_unlock (ctl_unlock),
    .ctl_enable (ctl_enable),
    .busy       (busy),
    .cnv_req    (cnv_req),
    .cnv_done   (cnv_done),
    .res_valid  (res_valid),
    .res_tag    (res_tag)
);

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
    import adc_seq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tbl_we = 1'b0;
    logic [4:0]        tbl_addr = '0;
    logic [ENT_W-1:0]  tbl_wdata = '0;
    logic              tmr_we = 1'b0;
    logic [1:0]        tmr_sel = '0;
    logic [9:0]        tmr_wdata = '0;
    logic              ctl_unlock = 1'b0;
    logic              ctl_enable = 1'b1;
    logic              ctl_trigger = 1'b0;
    logic [4:0]        ctl_entry = '0;
    logic              busy;
    logic              cnv_req;
    logic [4:0]        cnv_chan;
    logic              cnv_done = 1'b0;
    logic [11:0]       cnv_data = '0;
    logic              res_valid;
    logic [4:0]        res_tag;
    logic [11:0]       res_data;

    adc_scan_seq uut (.*);

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    logic [ENT_W-1:0] tb_tab [32];
    int cv_tag [4096];
    int cv_data [4096];
    int rs_tag [4096];
    int rs_data [4096];
    int n_conv = 0;
    int nr = 0;
    int pend = 0;
    int pend_tag = 0;
    int overlap = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Converter model: answers two cycles after each request.
    initial forever begin
        @(negedge clk);
        cnv_done = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                cnv_done = 1'b1;
                cnv_data = 12'((pend_tag * 37 + n_conv * 13 + 5) % 4096);
                if (n_conv < 4096) begin
                    cv_tag[n_conv]  = pend_tag;
                    cv_data[n_conv] = int'(cnv_data);
                end
                n_conv++;
            end
        end
        if (cnv_req) begin
            if (pend != 0 || cnv_done) overlap++;
            pend_tag = int'(cnv_chan);
            pend = 2;
        end
    end

    initial forever begin
        @(negedge clk);
        if (res_valid && nr < 4096) begin
            rs_tag[nr]  = int'(res_tag);
            rs_data[nr] = int'(res_data);
            nr++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    function automatic logic [ENT_W-1:0] mk(input int mask, input bit m0on, input int m0sel,
        input bit m1on, input int m1sel, input bit tson, input int tsel,
        input bit avon, input int alog, input int nxt);
        logic [ENT_W-1:0] v;
        v = '0;
        v[7:0]   = 8'(mask);
        v[8]     = m0on;
        v[12:9]  = 4'(m0sel);
        v[13]    = m1on;
        v[17:14] = 4'(m1sel);
        v[18]    = tson;
        v[20:19] = 2'(tsel);
        v[21]    = avon;
        v[23:22] = 2'(alog);
        v[25:24] = 2'(nxt);
        return v;
    endfunction

    task automatic put_ent(input int a, input logic [ENT_W-1:0] v);
        tb_tab[a] = v;
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 5'(a); tbl_wdata = v;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic put_tmr(input int s, input int n);
        @(negedge clk);
        tmr_we = 1'b1; tmr_sel = 2'(s); tmr_wdata = 10'(n);
        @(negedge clk);
        tmr_we = 1'b0;
    endtask

    task automatic clr_logs();
        n_conv = 0; nr = 0;
    endtask

    task automatic do_trig(input int e);
        @(negedge clk);
        ctl_unlock = 1'b1; ctl_trigger = 1'b1; ctl_entry = 5'(e);
        @(negedge clk);
        ctl_unlock = 1'b0; ctl_trigger = 1'b0;
    endtask

    task automatic do_abort();
        @(negedge clk);
        ctl_unlock = 1'b1; ctl_enable = 1'b0;
        @(negedge clk);
        ctl_unlock = 1'b0; ctl_enable = 1'b1;
    endtask

    task automatic wait_idle(input string rq);
        int t;
        t = 0;
        while (busy && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (busy) chk(1'b0, rq, "scan did not end", t, 5000);
        repeat (4) @(negedge clk);
    endtask

    // Expected results computed from the bench copy of the table.
    task automatic walk(input int start, input string rq, input bit prefix);
        int e, ri, lp, it, tag, n, sh, sum, ex, fa, fe, nx;
        bit stop, bad, on;
        logic [ENT_W-1:0] en;
        e = start; ri = 0; lp = 0; it = 0; stop = 0; bad = 0; fa = 0; fe = 0;
        while (!stop && it < 400) begin
            it++;
            en = tb_tab[e];
            for (int s = 0; s < 10; s++) begin
                on = (s < 8) ? en[s] : ((s == 8) ? en[8] : en[13]);
                if (!on) continue;
                if (prefix && ri >= nr) begin stop = 1; break; end
                tag = (s < 8) ? s : 16 + ((s == 8) ? int'(en[12:9]) : int'(en[17:14]));
                sh  = en[21] ? int'(en[23:22]) : 0;
                n   = 1 << sh;
                sum = 0;
                for (int k = 0; k < n; k++) begin
                    if (lp + k >= 4096 || cv_tag[lp + k] != tag) begin
                        if (!bad) begin fa = (lp + k < 4096) ? cv_tag[lp + k] : -1; fe = tag; end
                        bad = 1;
                    end else sum += cv_data[lp + k];
                end
                lp += n;
                ex = sum >> sh;
                if (ri >= nr || rs_tag[ri] != tag || rs_data[ri] != ex) begin
                    if (!bad) begin fa = (ri < nr) ? rs_data[ri] : -1; fe = ex; end
                    bad = 1;
                end
                ri++;
            end
            if (!stop) begin
                nx = int'(en[25:24]);
                if (nx == 0 || nx == 2) stop = 1;
                else if (nx == 1) e = (e + 1) % 32;
                else e = start;
            end
        end
        if (!prefix && ri != nr) begin
            if (!bad) begin fa = nr; fe = ri; end
            bad = 1;
        end
        chk(!bad, rq, $sformatf("scan from entry %0d", start), fa, fe);
    endtask

    initial begin
        int base, gap, t, quiet;
        int tv [4];
        tv[0] = 0; tv[1] = 7; tv[2] = 300; tv[3] = 1023;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(busy == 1'b0, "R11", "busy after reset", int'(busy), 0);
        chk(cnv_req == 1'b0, "R11", "request after reset", int'(cnv_req), 0);
        chk(res_valid == 1'b0, "R11", "result after reset", int'(res_valid), 0);

        // R2 and R12: every direct mask on entry 3
        for (int m = 0; m < 256; m++) begin
            put_ent(3, mk(m, 0, 0, 0, 0, 0, 0, 0, 0, 0));
            clr_logs();
            do_trig(3);
            if (m == 1) chk(busy == 1'b1, "R1", "busy after trigger", int'(busy), 1);
            wait_idle("R2");
            if (m == 0) chk(n_conv == 0 && nr == 0, "R12", "empty entry requests", n_conv, 0);
            else walk(3, "R2", 0);
        end
        chk(overlap == 0, "R2", "overlapping requests", overlap, 0);

        // R2: mux select sweep on both multiplexers
        for (int s = 0; s < 16; s++) begin
            put_ent(7, mk(8'h81, 1, s, 1, 15 - s, 0, 0, 0, 0, 0));
            clr_logs();
            do_trig(7);
            wait_idle("R2");
            walk(7, "R2", 0);
        end

        // R4: averaging codes with averaging on and off
        for (int a = 0; a < 2; a++) begin
            for (int c = 0; c < 4; c++) begin
                put_ent(11, mk(8'h05, 1, 9, 0, 0, 0, 0, a, c, 0));
                clr_logs();
                do_trig(11);
                wait_idle("R4");
                walk(11, "R4", 0);
                chk(n_conv == 3 * (a ? (1 << c) : 1), "R4", "conversion count",
                    n_conv, 3 * (a ? (1 << c) : 1));
            end
        end

        // R3: sample delay per timer
        put_ent(2, mk(8'h01, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        @(negedge clk);
        ctl_unlock = 1'b1; ctl_trigger = 1'b1; ctl_entry = 5'd2;
        base = 0;
        do begin @(negedge clk); ctl_unlock = 1'b0; ctl_trigger = 1'b0; base++; end
        while (!cnv_req && base < 100);
        wait_idle("R3");
        for (int s = 0; s < 4; s++) begin
            put_tmr(s, tv[s]);
            put_ent(2, mk(8'h01, 0, 0, 0, 0, 1, s, 0, 0, 0));
            @(negedge clk);
            ctl_unlock = 1'b1; ctl_trigger = 1'b1; ctl_entry = 5'd2;
            gap = 0;
            do begin @(negedge clk); ctl_unlock = 1'b0; ctl_trigger = 1'b0; gap++; end
            while (!cnv_req && gap < 2000);
            chk(gap - base == tv[s] + 1, "R3", $sformatf("delay timer %0d", s),
                gap - base, tv[s] + 1);
            wait_idle("R3");
        end

        // R5: step with wrap from 31 to 0
        put_ent(30, mk(8'h02, 0, 0, 0, 0, 0, 0, 0, 0, 1));
        put_ent(31, mk(8'h10, 0, 0, 0, 0, 0, 0, 1, 1, 1));
        put_ent(0,  mk(8'h00, 1, 3, 0, 0, 0, 0, 0, 0, 0));
        clr_logs();
        do_trig(30);
        wait_idle("R5");
        walk(30, "R5", 0);
        chk(nr == 3, "R5", "results across wrap", nr, 3);

        // R12: empty entry steps straight on
        put_ent(20, mk(8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 1));
        put_ent(21, mk(8'h04, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        clr_logs();
        do_trig(20);
        wait_idle("R12");
        walk(20, "R12", 0);

        // R6: pause, then resume at stored start entry
        put_ent(5, mk(8'h08, 0, 0, 0, 0, 0, 0, 0, 0, 2));
        put_ent(9, mk(8'h40, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        clr_logs();
        do_trig(5);
        wait_idle("R6");
        chk(busy == 1'b0, "R6", "busy in pause", int'(busy), 0);
        walk(5, "R6", 0);
        clr_logs();
        do_trig(9);
        wait_idle("R6");
        walk(5, "R6", 0);
        // R10: abort the pause, then a trigger uses the entry input again
        do_abort();
        clr_logs();
        do_trig(9);
        wait_idle("R10");
        walk(9, "R10", 0);

        // R7: loop back to start at once, then R10 abort
        put_ent(12, mk(8'h03, 0, 0, 0, 0, 0, 0, 0, 0, 1));
        put_ent(13, mk(8'h20, 0, 0, 0, 0, 0, 0, 0, 0, 3));
        clr_logs();
        do_trig(12);
        t = 0;
        while (nr < 7 && t < 3000) begin @(negedge clk); t++; end
        chk(nr >= 7, "R7", "results while looping", nr, 7);
        do_abort();
        chk(busy == 1'b0, "R10", "busy after abort", int'(busy), 0);
        quiet = 0;
        repeat (20) begin @(negedge clk); if (cnv_req || busy) quiet++; end
        chk(quiet == 0, "R10", "activity after abort", quiet, 0);
        walk(12, "R7", 1);

        // R8: locked controls do nothing
        @(negedge clk);
        ctl_unlock = 1'b0; ctl_trigger = 1'b1; ctl_entry = 5'd3;
        quiet = 0;
        for (int k = 0; k < 10; k++) begin
            ctl_enable = k[0];
            @(negedge clk);
            if (busy) quiet++;
        end
        ctl_trigger = 1'b0; ctl_enable = 1'b1;
        chk(quiet == 0, "R8", "locked trigger started a scan", quiet, 0);
        put_ent(3, mk(8'hFF, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        clr_logs();
        do_trig(3);
        @(negedge clk);
        ctl_enable = 1'b0; ctl_trigger = 1'b1; ctl_entry = 5'd9;
        repeat (5) @(negedge clk);
        ctl_enable = 1'b1; ctl_trigger = 1'b0;
        wait_idle("R8");
        walk(3, "R8", 0);

        // R9: trigger during a scan is ignored
        clr_logs();
        do_trig(3);
        repeat (6) @(negedge clk);
        ctl_unlock = 1'b1; ctl_trigger = 1'b1; ctl_entry = 5'd9;
        @(negedge clk);
        ctl_unlock = 1'b0; ctl_trigger = 1'b0;
        wait_idle("R9");
        walk(3, "R9", 0);
        chk(nr == 8, "R9", "result count", nr, 8);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule